// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the host-facing register access stage of a two-channel serial controller. A narrow byte bus reaches four ports: a control port and a data port for each of the two channels. Most registers are not directly addressed. The host first writes a register number to a control port. The next access to a control port then reads or writes the selected register. A single pointer serves both channels, and it drops back to zero after every access, so software always starts a sequence from register zero.

The block holds the per-channel write registers. Two of them, the vector base and the master control, exist only once and are shared by both channels. It also holds the channel reset logic, which loads fixed non-zero values, and it drives the modem-control lines. Read registers are built from status inputs: receive-available, transmit-empty, clear-to-send, the interrupt-pending bits and the received byte. Bytes written for transmission leave as a one-cycle strobe.

Top module: `dual_chan_regfile`

## Requirements
- R1: `bus_addr[2:1]` selects the port: 0 is channel A control, 1 is channel A data, 2 is channel B control, 3 is channel B data. Only accesses with `bus_addr[0]`=1 take effect. A read with `bus_addr[0]`=0 returns 0xFF, and a write with `bus_addr[0]`=0 changes nothing.
- R2: While the pointer is 0, a control write of a value from 0 to 15 loads the pointer with that value. A larger value is a command: it leaves the pointer at 0 and changes no register.
- R3: Every other odd-address access, whether read or write, on a control or a data port, returns the pointer to 0. The next control access therefore addresses register 0.
- R4: The vector base (register 2) is one shared copy. A write from either channel is seen when pointer 2 is read on either channel.
- R5: After reset, both channels read 0xF8 at pointer 15, read 0x04 at pointer 4, and hold register 14 at 0xA0 and register 11 at 0x08. All RTS and DTR outputs are low.
- R6: Writing register 9 with bit 7 set resets channel A, and with bit 6 set resets channel B, whichever channel performs the write. A channel reset loads the values of R5 into that channel and clears the shared register 9. The other channel keeps its values.
- R7: Reading pointer 0 returns the live status byte and captures it. The byte carries receive-available in bit 0, transmit-empty in bit 2 and CTS in bit 5; all other bits are 0. Reading pointer 4 returns the last captured byte.
- R8: Reading pointer 3 returns the 6-bit interrupt-pending input, zero-extended, on channel A, and returns 0 on channel B.
- R9: Reading pointer 12 returns register 12 and reading pointer 13 returns register 13, both per channel. Reading pointer 9 also returns register 13.
- R10: Reading pointer 11 or 15 returns register 15 with bits 2 and 0 forced to 0, and also clears those two bits in the stored copy.
- R11: For each channel, RTS follows bit 1 of its register 5 and DTR follows bit 7.
- R12: A write to a data port, or a write through pointer 8, pulses that channel's `tx_strobe` high for exactly the one cycle after the write, with `tx_byte` holding the written byte.
- R13: A read of a data port, or a read through pointer 8, returns that channel's received-byte input. Any pointer not named in R7 to R10 or here reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Byte address; bit 0 must be 1, bits 2:1 select the port |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current address and pointer |
| rx_avail | input | 2 | Receive character available, per channel |
| tx_empty | input | 2 | Transmit buffer empty, per channel |
| cts_in | input | 2 | Clear-to-send, per channel |
| ipend | input | 6 | Interrupt-pending bits, read through channel A |
| rx_byte_a | input | 8 | Received byte, channel A |
| rx_byte_b | input | 8 | Received byte, channel B |
| tx_strobe | output | 2 | One-cycle transmit strobe, per channel |
| tx_byte | output | 8 | Byte that goes with the transmit strobe |
| rts | output | 2 | Request-to-send, per channel |
| dtr | output | 2 | Data-terminal-ready, per channel |

## Verification
The hardest case to reach from the ports is a reset of one channel ordered from the other channel. The pointer is shared and clears after each access, so the stimulus has to interleave pointer loads and writes across both control ports. The bench first places distinct, odd-valued bytes in register 15 of both channels. It then writes register 9 from channel B to reset channel A, and later from A to reset B. Read-backs at pointer 15 on both channels show which channel was reset and that the other kept its value. The captured status byte at pointer 4 is handled the same way: it is captured with live inputs, and the inputs are changed before the read-back.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int DW    = 8;
    localparam int NCH   = 2;
    localparam int NREG  = 16;
    localparam int PW    = $clog2(NREG);
    localparam int AW    = 3;
    localparam int IPW   = 6;

    localparam int REG_VBASE  = 2;
    localparam int REG_IPEND  = 3;
    localparam int REG_STCOPY = 4;
    localparam int REG_MODEM  = 5;
    localparam int REG_DATA   = 8;
    localparam int REG_MCTL   = 9;
    localparam int REG_CLKSRC = 11;
    localparam int REG_DIVLO  = 12;
    localparam int REG_DIVHI  = 13;
    localparam int REG_MISC   = 14;
    localparam int REG_EXTCTL = 15;

    localparam int ST_RXAV = 0;
    localparam int ST_TXBE = 2;
    localparam int ST_CTS  = 5;
    localparam int MD_RTS  = 1;
    localparam int MD_DTR  = 7;
    localparam int MC_RSTA = 7;
    localparam int MC_RSTB = 6;

    localparam logic [DW-1:0] RV_EXTCTL = 8'hF8;
    localparam logic [DW-1:0] RV_MISC   = 8'hA0;
    localparam logic [DW-1:0] RV_CLKSRC = 8'h08;
    localparam logic [DW-1:0] RV_STAT   = 8'h04;
    localparam logic [DW-1:0] EXT_MASK  = 8'hFA;
    localparam logic [DW-1:0] EVEN_READ = 8'hFF;

    typedef struct packed {
        logic [PW-1:0]                     ptr;
        logic [NCH-1:0][NREG-1:0][DW-1:0]  wreg;
        logic [DW-1:0]                     vbase;
        logic [DW-1:0]                     mctl;
        logic [NCH-1:0][DW-1:0]            stcap;
        logic [NCH-1:0]                    tx_stb;
        logic [DW-1:0]                     tx_byte;
    } dcr_state_t;

    function automatic dcr_state_t chan_reset(dcr_state_t s, int c);
        dcr_state_t r = s;
        r.wreg[c][REG_EXTCTL] = RV_EXTCTL;
        r.wreg[c][REG_MISC]   = RV_MISC;
        r.wreg[c][REG_CLKSRC] = RV_CLKSRC;
        r.mctl                = '0;
        r.stcap[c]            = RV_STAT;
        return r;
    endfunction
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
    import dcr_pkg::*;
(
    input  logic [AW-1:0] addr,
    output logic          odd,
    output logic          chan,
    output logic          is_ctrl
);
    always_comb begin
        odd     = addr[0];
        is_ctrl = ~addr[1];
        chan    = addr[2];
    end
endmodule

// File: rtl/dcr_readmux.sv
module dcr_readmux
    import dcr_pkg::*;
(
    input  logic                     odd,
    input  logic                     chan,
    input  logic                     is_ctrl,
    input  logic [PW-1:0]            ptr,
    input  logic [NREG-1:0][DW-1:0]  wreg,
    input  logic [DW-1:0]            vbase,
    input  logic [DW-1:0]            stcap,
    input  logic [DW-1:0]            stlive,
    input  logic [IPW-1:0]           ipend,
    input  logic [DW-1:0]            rx_byte,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] ctrl_val;

    always_comb begin
        case (int'(ptr))
            0:                   ctrl_val = stlive;
            REG_VBASE:           ctrl_val = vbase;
            REG_IPEND:           ctrl_val = chan ? '0 : DW'(ipend);
            REG_STCOPY:          ctrl_val = stcap;
            REG_DATA:            ctrl_val = rx_byte;
            REG_MCTL, REG_DIVHI: ctrl_val = wreg[REG_DIVHI];
            REG_DIVLO:           ctrl_val = wreg[REG_DIVLO];
            REG_CLKSRC,
            REG_EXTCTL:          ctrl_val = wreg[REG_EXTCTL] & EXT_MASK;
            default:             ctrl_val = '0;
        endcase
        if (!odd)
            rdata = EVEN_READ;
        else if (is_ctrl)
            rdata = ctrl_val;
        else
            rdata = rx_byte;
    end
endmodule

// File: rtl/dual_chan_regfile.sv
module dual_chan_regfile
    import dcr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NCH-1:0]  rx_avail,
    input  logic [NCH-1:0]  tx_empty,
    input  logic [NCH-1:0]  cts_in,
    input  logic [IPW-1:0]  ipend,
    input  logic [DW-1:0]   rx_byte_a,
    input  logic [DW-1:0]   rx_byte_b,
    output logic [NCH-1:0]  tx_strobe,
    output logic [DW-1:0]   tx_byte,
    output logic [NCH-1:0]  rts,
    output logic [NCH-1:0]  dtr
);
    dcr_state_t state_d, state_q;
    dcr_state_t rst_state;

    logic odd, chan, is_ctrl;
    logic [NCH-1:0][DW-1:0] st_live;
    logic [DW-1:0] rx_sel;

    // flattened views for the bound checker
    logic [PW-1:0]          ptr_q;
    logic [DW-1:0]          mctl_q;
    logic [NCH-1:0][DW-1:0] ext_q;
    logic [NCH-1:0][DW-1:0] misc_q;

    dcr_decode u_dec (
        .addr    (bus_addr),
        .odd     (odd),
        .chan    (chan),
        .is_ctrl (is_ctrl)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_comb begin
            st_live[c]          = '0;
            st_live[c][ST_RXAV] = rx_avail[c];
            st_live[c][ST_TXBE] = tx_empty[c];
            st_live[c][ST_CTS]  = cts_in[c];
        end
        assign rts[c]    = state_q.wreg[c][REG_MODEM][MD_RTS];
        assign dtr[c]    = state_q.wreg[c][REG_MODEM][MD_DTR];
        assign ext_q[c]  = state_q.wreg[c][REG_EXTCTL];
        assign misc_q[c] = state_q.wreg[c][REG_MISC];
    end

    assign rx_sel = chan ? rx_byte_b : rx_byte_a;

    dcr_readmux u_rmux (
        .odd     (odd),
        .chan    (chan),
        .is_ctrl (is_ctrl),
        .ptr     (state_q.ptr),
        .wreg    (state_q.wreg[chan]),
        .vbase   (state_q.vbase),
        .stcap   (state_q.stcap[chan]),
        .stlive  (st_live[chan]),
        .ipend   (ipend),
        .rx_byte (rx_sel),
        .rdata   (bus_rdata)
    );

    always_comb begin
        rst_state = '0;
        for (int c = 0; c < NCH; c++)
            rst_state = chan_reset(rst_state, c);
    end

    always_comb begin
        state_d        = state_q;
        state_d.tx_stb = '0;
        if (odd && bus_wr) begin
            if (!is_ctrl) begin
                state_d.tx_stb[chan] = 1'b1;
                state_d.tx_byte      = bus_wdata;
                state_d.ptr          = '0;
            end else if (state_q.ptr == '0) begin
                if (bus_wdata < DW'(NREG))
                    state_d.ptr = bus_wdata[PW-1:0];
            end else begin
                state_d.wreg[chan][state_q.ptr] = bus_wdata;
                case (int'(state_q.ptr))
                    REG_VBASE: state_d.vbase = bus_wdata;
                    REG_DATA: begin
                        state_d.tx_stb[chan] = 1'b1;
                        state_d.tx_byte      = bus_wdata;
                    end
                    REG_MCTL: begin
                        state_d.mctl = bus_wdata;
                        if (bus_wdata[MC_RSTB]) state_d = chan_reset(state_d, 1);
                        if (bus_wdata[MC_RSTA]) state_d = chan_reset(state_d, 0);
                    end
                    default: ;
                endcase
                state_d.ptr = '0;
            end
        end else if (odd && bus_rd) begin
            if (is_ctrl) begin
                if (state_q.ptr == '0)
                    state_d.stcap[chan] = st_live[chan];
                if (int'(state_q.ptr) == REG_CLKSRC || int'(state_q.ptr) == REG_EXTCTL)
                    state_d.wreg[chan][REG_EXTCTL] = state_q.wreg[chan][REG_EXTCTL] & EXT_MASK;
            end
            state_d.ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= rst_state;
        else
            state_q <= state_d;
    end

    assign tx_strobe = state_q.tx_stb;
    assign tx_byte   = state_q.tx_byte;
    assign ptr_q     = state_q.ptr;
    assign mctl_q    = state_q.mctl;
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker
    import dcr_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [AW-1:0]          bus_addr,
    input logic                   bus_rd,
    input logic                   bus_wr,
    input logic [DW-1:0]          bus_wdata,
    input logic [DW-1:0]          bus_rdata,
    input logic [NCH-1:0]         tx_strobe,
    input logic [DW-1:0]          tx_byte,
    input logic [PW-1:0]          ptr_q,
    input logic [DW-1:0]          mctl_q,
    input logic [NCH-1:0][DW-1:0] ext_q,
    input logic [NCH-1:0][DW-1:0] misc_q
);
    logic ctrl_wr, ptr_load;
    assign ctrl_wr  = bus_wr && bus_addr[0] && !bus_addr[1];
    assign ptr_load = ctrl_wr && ptr_q == '0;

    assert_even_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr[0]) |-> bus_rdata == EVEN_READ);

    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load && bus_wdata < DW'(NREG)) |=> ptr_q == $past(bus_wdata[PW-1:0]));

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[0] && ((bus_wr && !ptr_load) || (bus_rd && !bus_wr))) |=> ptr_q == '0);

    assert_reset_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && int'(ptr_q) == REG_MCTL && bus_wdata[MC_RSTA])
        |=> (ext_q[0] == RV_EXTCTL && misc_q[0] == RV_MISC && mctl_q == '0));

    assert_reset_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && int'(ptr_q) == REG_MCTL && bus_wdata[MC_RSTB])
        |=> (ext_q[1] == RV_EXTCTL && misc_q[1] == RV_MISC && mctl_q == '0));

    assert_ext_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr[0] && !bus_addr[1]
         && (int'(ptr_q) == REG_CLKSRC || int'(ptr_q) == REG_EXTCTL))
        |=> (ext_q[$past(bus_addr[2])][2] == 1'b0 && ext_q[$past(bus_addr[2])][0] == 1'b0));

    assert_tx_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0] && bus_addr[1])
        |=> (tx_strobe[$past(bus_addr[2])] && tx_byte == $past(bus_wdata)));

    assert_tx_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_strobe) |-> $past(bus_wr));
endmodule

bind dual_chan_regfile dcr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte),
    .ptr_q     (ptr_q),
    .mctl_q    (mctl_q),
    .ext_q     (ext_q),
    .misc_q    (misc_q)
);

// File: tb/dual_chan_regfile_test.sv
module dual_chan_regfile_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'b001;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] rx_avail = '0;
    logic [1:0] tx_empty = '0;
    logic [1:0] cts_in = '0;
    logic [5:0] ipend = '0;
    logic [7:0] rx_byte_a = '0;
    logic [7:0] rx_byte_b = '0;
    logic [1:0] tx_strobe;
    logic [7:0] tx_byte;
    logic [1:0] rts;
    logic [1:0] dtr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [2:0] CA = 3'b001, DA = 3'b011, CB = 3'b101, DB = 3'b111;

    always #10 clk = ~clk;

    dual_chan_regfile uut (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [2:0] cport(int ch);
        return ch ? CB : CA;
    endfunction

    task automatic reg_write(int ch, logic [7:0] r, logic [7:0] v);
        bus_write(cport(ch), r);
        bus_write(cport(ch), v);
    endtask

    task automatic reg_read(int ch, logic [7:0] r, output logic [7:0] v);
        bus_write(cport(ch), r);
        bus_read(cport(ch), v);
    endtask

    task automatic t_reset_R5;
        logic [7:0] v;
        check("R5 rts", {6'b0, rts}, 8'h00);
        check("R5 dtr", {6'b0, dtr}, 8'h00);
        check("R5 strobe", {6'b0, tx_strobe}, 8'h00);
        reg_read(0, 15, v); check("R5 A ptr15", v, 8'hF8);
        reg_read(1, 15, v); check("R5 B ptr15", v, 8'hF8);
        reg_read(0, 4, v);  check("R5 A ptr4", v, 8'h04);
        reg_read(1, 4, v);  check("R5 B ptr4", v, 8'h04);
    endtask

    task automatic t_decode_R1;
        logic [7:0] v;
        rx_avail = 2'b01; tx_empty = 2'b11; cts_in = 2'b01;
        rx_byte_a = 8'h5C;
        bus_read(3'b000, v); check("R1 even read", v, 8'hFF);
        bus_read(3'b110, v); check("R1 even read B", v, 8'hFF);
        bus_write(3'b000, 8'h0C);
        bus_read(CA, v); check("R1 even write ignored", v, 8'h25);
        bus_read(DA, v); check("R1 data port A", v, 8'h5C);
    endtask

    task automatic t_pointer_R2_R3;
        logic [7:0] v;
        bus_write(CA, 8'h20);
        bus_read(CA, v); check("R2 command leaves ptr 0", v, 8'h25);
        reg_write(0, 12, 8'h5A);
        reg_read(0, 12, v); check("R2 pointer load", v, 8'h5A);
        bus_read(CA, v); check("R3 ptr cleared after read", v, 8'h25);
        bus_write(CA, 8'd12);
        bus_read(DA, v);
        bus_read(CA, v); check("R3 ptr cleared by data read", v, 8'h25);
        bus_write(CB, 8'd12);
        bus_write(DB, 8'h00);
        bus_read(CA, v); check("R3 ptr cleared by data write", v, 8'h25);
    endtask

    task automatic t_vbase_R4;
        logic [7:0] v;
        reg_write(1, 2, 8'h40);
        reg_read(0, 2, v); check("R4 B write A read", v, 8'h40);
        reg_write(0, 2, 8'h77);
        reg_read(1, 2, v); check("R4 A write B read", v, 8'h77);
    endtask

    task automatic t_chan_reset_R6;
        logic [7:0] v;
        reg_write(0, 15, 8'h33);
        reg_write(1, 15, 8'h11);
        bus_read(CA, v);
        reg_write(1, 9, 8'h80);
        reg_read(0, 15, v); check("R6 A reset from B", v, 8'hF8);
        reg_read(1, 15, v); check("R6 B untouched", v, 8'h10);
        reg_read(0, 4, v);  check("R6 A status copy", v, 8'h04);
        reg_write(0, 15, 8'h33);
        reg_write(0, 9, 8'h40);
        reg_read(1, 15, v); check("R6 B reset from A", v, 8'hF8);
        reg_read(0, 15, v); check("R6 A untouched", v, 8'h32);
    endtask

    task automatic t_status_R7;
        logic [7:0] v;
        rx_avail = 2'b10; tx_empty = 2'b10; cts_in = 2'b10;
        bus_read(CB, v); check("R7 B live", v, 8'h25);
        rx_avail = 2'b00; tx_empty = 2'b00; cts_in = 2'b00;
        reg_read(1, 4, v); check("R7 B captured", v, 8'h25);
        bus_read(CB, v); check("R7 B live zero", v, 8'h00);
        tx_empty = 2'b01;
        bus_read(CA, v); check("R7 A live", v, 8'h04);
    endtask

    task automatic t_ipend_R8;
        logic [7:0] v;
        ipend = 6'h2D;
        reg_read(0, 3, v); check("R8 A ipend", v, 8'h2D);
        reg_read(1, 3, v); check("R8 B zero", v, 8'h00);
    endtask

    task automatic t_divisor_R9;
        logic [7:0] v;
        reg_write(0, 12, 8'h0B);
        reg_write(0, 13, 8'h3C);
        reg_write(1, 13, 8'hC1);
        reg_read(0, 12, v); check("R9 A ptr12", v, 8'h0B);
        reg_read(0, 13, v); check("R9 A ptr13", v, 8'h3C);
        reg_read(0, 9, v);  check("R9 A ptr9", v, 8'h3C);
        reg_read(1, 9, v);  check("R9 B ptr9", v, 8'hC1);
    endtask

    task automatic t_ext_R10;
        logic [7:0] v;
        reg_write(1, 15, 8'hFF);
        reg_read(1, 15, v); check("R10 masked read", v, 8'hFA);
        reg_read(1, 11, v); check("R10 ptr11 read", v, 8'hFA);
        reg_read(1, 15, v); check("R10 stays masked", v, 8'hFA);
    endtask

    task automatic t_modem_R11;
        reg_write(0, 5, 8'h82);
        check("R11 rts A set", {6'b0, rts}, 8'h01);
        check("R11 dtr A set", {6'b0, dtr}, 8'h01);
        reg_write(0, 5, 8'h02);
        check("R11 dtr A clear", {6'b0, dtr}, 8'h00);
        reg_write(1, 5, 8'h80);
        check("R11 dtr B set", {6'b0, dtr}, 8'h02);
        check("R11 rts B low", {6'b0, rts}, 8'h01);
    endtask

    task automatic t_tx_R12;
        @(negedge clk);
        bus_addr = DB; bus_wdata = 8'hA5; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R12 strobe B", {6'b0, tx_strobe}, 8'h02);
        check("R12 byte B", tx_byte, 8'hA5);
        @(negedge clk);
        check("R12 strobe ends", {6'b0, tx_strobe}, 8'h00);
        bus_write(CA, 8'd8);
        @(negedge clk);
        bus_addr = CA; bus_wdata = 8'h3C; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R12 strobe A via ptr8", {6'b0, tx_strobe}, 8'h01);
        check("R12 byte A", tx_byte, 8'h3C);
    endtask

    task automatic t_rx_R13;
        logic [7:0] v;
        rx_byte_b = 8'h9E;
        bus_read(DB, v);   check("R13 data port B", v, 8'h9E);
        reg_read(1, 8, v); check("R13 ptr8 B", v, 8'h9E);
        reg_read(0, 6, v); check("R13 undecoded ptr", v, 8'h00);
        reg_read(0, 14, v); check("R13 ptr14 zero", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_R5;
        t_decode_R1;
        t_pointer_R2_R3;
        t_vbase_R4;
        t_chan_reset_R6;
        t_status_R7;
        t_ipend_R8;
        t_divisor_R9;
        t_ext_R10;
        t_modem_R11;
        t_tx_R12;
        t_rx_R13;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule